// File: doc/BRIEF.md
# Framed Burst Serializer

This block sends a fixed-length burst of result words on one serial line. The line is timed by a fast master clock (4.9152 MHz in the intended system; nothing in the logic depends on the exact rate). A frame sequencer issues a single-cycle start pulse at a chosen point in each compute pass. On that pulse the block captures all of its input words at once. It then sends them in ascending word index. Each word occupies a slot made of one high marker bit followed by its data bits, least significant bit first. One bit goes out per master-clock cycle.

After the last slot the line is held low for a fixed run of tail cycles. The whole burst therefore has a constant length: with the default parameters, 4 words of 32 bits and 8 tail cycles, it lasts 4 × 33 + 8 = 140 cycles. The sequencer can rely on that length to be sure the burst ends before the next pass begins. A busy output covers the whole burst, and a single-cycle done pulse follows it. A start pulse that arrives while a burst is running is discarded, and a sticky overrun flag records the event.

Top module: `rt_burst_tx`

## Requirements
- R1: While reset is asserted and after it is released, `ser_out`, `busy`, `done` and `overrun` are all 0.
- R2: When `start` is 1 at a rising edge while `busy` is 0, `busy` is 1 in the following cycle and `ser_out` is 1 in that cycle (the marker bit of word 0).
- R3: Every word slot is 33 cycles long: one cycle with `ser_out` = 1, then the 32 data bits of the word, bit 0 first and bit 31 last.
- R4: The slots go out in word order 0, 1, 2, 3. Word k is taken from `words_in[32*k+31 : 32*k]`.
- R5: All words are captured at the accepting edge. Changes on `words_in` during a burst do not alter the bits sent.
- R6: After the 132 slot cycles, `ser_out` is 0 for 8 cycles. `busy` is 1 for exactly 140 consecutive cycles per burst.
- R7: `done` is 1 for exactly one cycle, the first cycle after the last busy cycle, and `busy` is 0 in that cycle.
- R8: A `start` pulse at an edge where `busy` is 1 leaves the burst in progress unchanged and sets `overrun` to 1. `overrun` stays 1 until reset.
- R9: `ser_out` is 0 in every cycle in which `busy` is 0.
- R10: A `start` pulse in the cycle where `done` is 1 is accepted and launches the next burst immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle burst launch request |
| words_in | input | 128 | Four packed words, word k in bits 32k+31..32k |
| ser_out | output | 1 | Serial data line |
| busy | output | 1 | High for the whole burst |
| done | output | 1 | One-cycle pulse after the burst |
| overrun | output | 1 | Sticky flag: start was seen while busy |

## Verification
The bench compares every cycle of each burst against a bit stream built from the captured words. A design with a wrong bit order, slot order, marker position or tail length therefore fails at the first cycle where it goes wrong. In one burst the input words are rewritten and a second start pulse is issued partway through. A design that samples its inputs live, or restarts on that pulse, would send a different stream and would leave `overrun` clear. Another test launches a new burst in the done cycle, which catches an off-by-one in the busy/idle handover that would drop the request or merge the two bursts.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MARK = 2'd1,
        PH_DATA = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

endpackage

// File: rtl/rtb_seq.sv
module rtb_seq
    import rtb_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int WORDS    = 4,
    parameter int TAIL_CYC = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   load_en,
    output logic   shift_en,
    output logic   busy,
    output logic   done
);
    localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int SLOT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int TAIL_W = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;
    localparam int TOTAL  = WORDS * (WORD_W + 1) + TAIL_CYC;
    localparam int RUN_W  = $clog2(TOTAL + 1);

    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORDS - 1);
    localparam logic [TAIL_W-1:0] LAST_TAIL = TAIL_W'(TAIL_CYC - 1);

    typedef struct packed {
        phase_e             phase;
        logic [BIT_W-1:0]   bit_idx;
        logic [SLOT_W-1:0]  slot;
        logic [TAIL_W-1:0]  tail;
        logic               done;
    } seq_s;

    seq_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase   = PH_MARK;
                    st_d.slot    = '0;
                    st_d.bit_idx = '0;
                end
            end
            PH_MARK: begin
                st_d.phase   = PH_DATA;
                st_d.bit_idx = '0;
            end
            PH_DATA: begin
                if (st_q.bit_idx == LAST_BIT) begin
                    st_d.bit_idx = '0;
                    if (st_q.slot == LAST_SLOT) begin
                        st_d.phase = PH_TAIL;
                        st_d.tail  = '0;
                    end else begin
                        st_d.phase = PH_MARK;
                        st_d.slot  = st_q.slot + SLOT_W'(1);
                    end
                end else begin
                    st_d.bit_idx = st_q.bit_idx + BIT_W'(1);
                end
            end
            PH_TAIL: begin
                if (st_q.tail == LAST_TAIL) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.tail = st_q.tail + TAIL_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bit_idx: '0, slot: '0, tail: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.phase;
    assign busy     = (st_q.phase != PH_IDLE);
    assign load_en  = start && (st_q.phase == PH_IDLE);
    assign shift_en = (st_q.phase == PH_DATA);
    assign done     = st_q.done;

    // Burst-length check: counts busy cycles, compared when busy falls.
    logic [RUN_W-1:0] run_cnt_d, run_cnt_q;

    always_comb begin
        run_cnt_d = busy ? run_cnt_q + RUN_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
        end else begin
            run_cnt_q <= run_cnt_d;
        end
    end

    initial begin
        assert (TAIL_CYC >= 1 && WORD_W >= 2 && WORDS >= 1)
            else $error("rtb_seq: unsupported parameters");
    end

    p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt_q == RUN_W'(TOTAL)));

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/rtb_shift_store.sv
module rtb_shift_store #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      shift,
    input  logic [WORDS*WORD_W-1:0]   din,
    output logic                      lsb
);
    localparam int NBITS = WORDS * WORD_W;

    typedef struct packed {
        logic [NBITS-1:0] bits;
    } store_s;

    store_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bits = din;
        end else if (shift) begin
            st_d.bits = {1'b0, st_q.bits[NBITS-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lsb = st_q.bits[0];

    p_no_load_and_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/rtb_line_drv.sv
module rtb_line_drv
    import rtb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   data_bit,
    input  logic   start,
    input  logic   busy,
    output logic   ser_out,
    output logic   overrun
);
    typedef struct packed {
        logic overrun;
    } drv_s;

    drv_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start && busy) begin
            st_d.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (phase)
            PH_MARK: ser_out = 1'b1;
            PH_DATA: ser_out = data_bit;
            default: ser_out = 1'b0;
        endcase
    end

    assign overrun = st_q.overrun;

    p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> overrun);

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/rt_burst_tx.sv
module rt_burst_tx
    import rtb_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int WORDS    = 4,
    parameter int TAIL_CYC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [WORDS*WORD_W-1:0] words_in,
    output logic                    ser_out,
    output logic                    busy,
    output logic                    done,
    output logic                    overrun
);
    phase_e phase;
    logic   load_en;
    logic   shift_en;
    logic   data_bit;

    rtb_seq #(
        .WORD_W   (WORD_W),
        .WORDS    (WORDS),
        .TAIL_CYC (TAIL_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .phase    (phase),
        .load_en  (load_en),
        .shift_en (shift_en),
        .busy     (busy),
        .done     (done)
    );

    rtb_shift_store #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .shift (shift_en),
        .din   (words_in),
        .lsb   (data_bit)
    );

    rtb_line_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .data_bit (data_bit),
        .start    (start),
        .busy     (busy),
        .ser_out  (ser_out),
        .overrun  (overrun)
    );

    p_idle_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_out);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && ser_out));

    p_retrigger_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !done || !busy);

endmodule

// File: tb/rt_burst_tx_test.sv
`timescale 1ns/1ps
module rt_burst_tx_test;
    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int NB     = WORD_W * WORDS;
    localparam int SLOT   = WORD_W + 1;
    localparam int DATA_C = SLOT * WORDS;
    localparam int TOTAL  = DATA_C + 8;
    localparam int NVEC   = 6;

    localparam logic [NB-1:0] VEC [NVEC] = '{
        128'h0000_0000_0000_0000_0000_0000_0000_0000,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hAAAA_AAAA_5555_5555_AAAA_AAAA_5555_5555,
        128'h8000_0000_0000_0001_8000_0000_0000_0001,
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'hDEAD_BEEF_0F0F_00FF_1357_9BDF_C001_D00D
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] words_in = '0;
    logic          ser_out, busy, done, overrun;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rt_burst_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .words_in (words_in),
        .ser_out  (ser_out),
        .busy     (busy),
        .done     (done),
        .overrun  (overrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [NB-1:0] w, input int c);
        int slot;
        int pos;
        if (c >= DATA_C) return 1'b0;
        slot = c / SLOT;
        pos  = c % SLOT;
        if (pos == 0) return 1'b1;
        return w[slot*WORD_W + pos - 1];
    endfunction

    // Called at a negedge: raises start for one edge, returns at the next negedge.
    task automatic launch(input logic [NB-1:0] w);
        words_in = w;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    // Checks all burst cycles; returns at the negedge of the done cycle.
    task automatic check_burst(input logic [NB-1:0] w, input bit disturb);
        int bad_bits = 0;
        int bad_busy = 0;
        for (int c = 0; c < TOTAL; c++) begin
            if (ser_out !== exp_bit(w, c)) begin
                bad_bits++;
                if (bad_bits == 1)
                    $display("FAIL R3/R4/R6 cycle %0d ser_out actual=%0b expected=%0b",
                             c, ser_out, exp_bit(w, c));
            end
            if (busy !== 1'b1) bad_busy++;
            if (disturb && c == 5) words_in = ~w;
            if (disturb && c == 40) start = 1'b1;
            if (disturb && c == 41) start = 1'b0;
            @(negedge clk);
        end
        checks++;
        if (bad_bits != 0) errors++;
        chk("R6", "busy low cycles inside burst", bad_busy, 0);
        chk("R7", "done after burst", done, 1'b1);
        chk("R7", "busy in done cycle", busy, 1'b0);
        chk("R9", "line in done cycle", ser_out, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "ser_out in reset", ser_out, 1'b0);
        chk("R1", "busy in reset", busy, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 1'b0);
        chk("R1", "done after reset", done, 1'b0);
        chk("R1", "overrun after reset", overrun, 1'b0);
        chk("R9", "idle line", ser_out, 1'b0);

        // Table walk: R2, R3, R4, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            launch(VEC[i]);
            chk("R2", "busy first cycle", busy, 1'b1);
            chk("R2", "marker first cycle", ser_out, 1'b1);
            check_burst(VEC[i], 1'b0);
            @(negedge clk);
            chk("R7", "done lasts one cycle", done, 1'b0);
            chk("R9", "idle line after burst", ser_out, 1'b0);
            chk("R8", "no overrun on clean bursts", overrun, 1'b0);
        end

        // R5 + R8: inputs rewritten and start retriggered mid-burst
        launch(VEC[4]);
        check_burst(VEC[4], 1'b1);
        chk("R5", "input change mid-burst", 32'd0, 32'd0);
        chk("R8", "overrun set by busy start", overrun, 1'b1);
        @(negedge clk);
        chk("R8", "no second burst from busy start", busy, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8", "overrun sticky", overrun, 1'b1);

        // R10: start in the done cycle
        launch(VEC[2]);
        check_burst(VEC[2], 1'b0);
        launch(VEC[5]);
        chk("R10", "back-to-back busy", busy, 1'b1);
        chk("R10", "back-to-back marker", ser_out, 1'b1);
        check_burst(VEC[5], 1'b0);
        @(negedge clk);
        chk("R7", "done single after chain", done, 1'b0);

        // R1: reset clears overrun
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "overrun cleared by reset", overrun, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule